// File: doc/BRIEF.md
# Debug Halt Source Controller

This block decides when a processor core enters the debug halted state and how it leaves it. It watches six halt causes: a fault-on-fault indication, a hardware breakpoint trigger, a decoded HALT instruction with the current privilege level, an external breakpoint input, the period just after reset release, and the core's STOP state. Some causes halt the core on the very next clock. The hardware breakpoint and the external breakpoint in normal running only arm a pending flag, and that flag is acted on at an instruction-boundary sample point.

While the core is halted, the block drives a halt request, shows the halted code on the processor status output and keeps a one-hot record of the cause that won. A GO strobe from the serial debug decoder releases the core. A resume-kind code tells the core where to continue: the next instruction, a program counter written by the debugger, or the normal reset exception sequence after a halt taken in the post-reset window. After reset release the block counts a fixed wait period and then signals the start of reset exception processing, unless the external breakpoint caught the window first.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: While `rst` is high and on the cycle after it, `halt_o`, `priv_viol_o`, `resume_o` and `rst_exc_o` are 0, `pst_o` is 0x0 and `src_o` is 0.
- R2: If no halt is taken after reset release, `rst_exc_o` is 1 for exactly one cycle, in the cycle after the 16th rising edge with `rst` low. It is 0 after the 15th edge.
- R3: If `ext_bkpt_i` is high at any of the first 8 rising edges after reset release, `halt_o` is 1 after that edge, `src_o` is 0001 and `rst_exc_o` never pulses. At the 9th edge or later, the input causes no halt during the wait period.
- R4: GO after a post-reset-window halt gives `resume_kind_o` = 01 (jump to loaded PC) if `pc_wr_i` pulsed while halted, and 10 (run reset exception processing) otherwise.
- R5: `fof_i` high while running sets `halt_o` after that same edge, with `src_o` = 1000.
- R6: `halt_insn_i` in supervisor mode (`user_mode_i`=0), or in user mode with `uhe_i`=1, halts after that edge with `src_o` = 0010. GO then resumes with `resume_kind_o` = 00 (next instruction) unless the PC was written.
- R7: `halt_insn_i` with `user_mode_i`=1 and `uhe_i`=0 raises `priv_viol_o` for one cycle and does not halt.
- R8: A `hwbp_i` or `ext_bkpt_i` pulse while running sets a pending flag without halting. The halt happens at the first later edge with `insn_bound_i` high. A boundary in the same cycle as the trigger does not take it.
- R9: When several causes act at the same edge, `src_o` holds only the highest one. Priority from high to low: fault-on-fault (1000), hardware breakpoint (0100), HALT instruction (0010), external breakpoint (0001).
- R10: `ext_bkpt_i` high while `stopped_i` is high halts after that edge without waiting for a boundary, with `src_o` = 0001. GO resumes with `resume_kind_o` = 00.
- R11: `pst_o` is 0xF in every cycle in which `halt_o` is 1, and 0x0 otherwise.
- R12: GO while halted drops `halt_o` and pulses `resume_o` for one cycle, both after the same edge. GO while not halted changes no output.
- R13: `src_o` keeps its value after resume until the next halt entry or reset. Taking a halt clears every pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fof_i | input | 1 | Fault-on-fault indication |
| hwbp_i | input | 1 | Hardware breakpoint trigger |
| halt_insn_i | input | 1 | HALT instruction being executed |
| user_mode_i | input | 1 | Core is in user mode |
| uhe_i | input | 1 | User-mode HALT allowed |
| ext_bkpt_i | input | 1 | External breakpoint input |
| stopped_i | input | 1 | Core is in the STOP state |
| insn_bound_i | input | 1 | Instruction-boundary sample point |
| go_i | input | 1 | GO strobe from the serial decoder |
| pc_wr_i | input | 1 | Debugger wrote the PC |
| halt_o | output | 1 | Halt request to the core |
| pst_o | output | 4 | Processor status code |
| src_o | output | 4 | One-hot recorded halt cause |
| priv_viol_o | output | 1 | Privilege-violation request |
| resume_o | output | 1 | Resume pulse |
| resume_kind_o | output | 2 | Resume target code |
| rst_exc_o | output | 1 | Start reset exception processing |

## Verification
The main same-cycle conflict is between an immediate cause and a pending flag that is consumed at a boundary. The bench arms both pending flags, then at one edge raises `insn_bound_i` together with `fof_i` and a permitted `halt_insn_i`. It expects `src_o` to be 1000 and, on later rounds with the higher causes removed, 0100 and then 0010. A second collision puts a breakpoint trigger on the same edge as a boundary. The bench requires that boundary to pass without a halt and the next one to take it.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  localparam int SRC_W = 4;
  // one-hot cause bit positions; higher index wins
  localparam int SRC_EXT  = 0;
  localparam int SRC_INSN = 1;
  localparam int SRC_HW   = 2;
  localparam int SRC_FOF  = 3;

  localparam logic [3:0] PST_HALTED  = 4'hF;
  localparam logic [3:0] PST_RUNNING = 4'h0;

  typedef enum logic [1:0] {
    RES_NEXT  = 2'd0,
    RES_PC    = 2'd1,
    RES_RESET = 2'd2
  } resume_kind_t;
endpackage

// File: rtl/dbg_rst_window.sv
module dbg_rst_window #(
  parameter int WAIT_CYC = 16,
  parameter int WIN_CYC  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic abort_i,
  output logic waiting_o,
  output logic in_win_o,
  output logic done_o
);
  localparam int CW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(WAIT_CYC - 1);
  localparam logic [CW-1:0] WIN  = CW'(WIN_CYC);

  logic [CW-1:0] cnt_q;
  logic          wait_q;

  assign waiting_o = wait_q;
  assign in_win_o  = wait_q && (cnt_q < WIN);
  assign done_o    = wait_q && (cnt_q == LAST) && !abort_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      wait_q <= 1'b1;
    end else if (wait_q) begin
      if (abort_i || cnt_q == LAST) wait_q <= 1'b0;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    wait_q |-> cnt_q <= LAST);
  assert_wait_ends_R2: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !waiting_o);
endmodule

// File: rtl/dbg_pend_flags.sv
module dbg_pend_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         arm_i,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk) begin
      if (rst)                    f_q <= 1'b0;
      else if (clr_i)             f_q <= 1'b0;
      else if (arm_i && set_i[i]) f_q <= 1'b1;
    end
    assign pend_o[i] = f_q;
  end

  assert_pend_clear_R13: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> pend_o == '0);
endmodule

// File: rtl/dbg_halt_prio.sv
module dbg_halt_prio #(
  parameter int W = 4
) (
  input  logic [W-1:0] req_i,
  output logic [W-1:0] win_o
);
  for (genvar i = 0; i < W; i++) begin : g_prio
    if (i == W - 1) begin : g_top
      assign win_o[i] = req_i[i];
    end else begin : g_low
      assign win_o[i] = req_i[i] && !(|req_i[W-1:i+1]);
    end
  end

  always_comb begin
    assert_prio_onehot_R9: assert ($onehot0(win_o));
  end
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
#(
  parameter int RST_WAIT = 16,
  parameter int RST_WIN  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fof_i,
  input  logic       hwbp_i,
  input  logic       halt_insn_i,
  input  logic       user_mode_i,
  input  logic       uhe_i,
  input  logic       ext_bkpt_i,
  input  logic       stopped_i,
  input  logic       insn_bound_i,
  input  logic       go_i,
  input  logic       pc_wr_i,
  output logic       halt_o,
  output logic [3:0] pst_o,
  output logic [3:0] src_o,
  output logic       priv_viol_o,
  output logic       resume_o,
  output logic [1:0] resume_kind_o,
  output logic       rst_exc_o
);
  localparam int NPEND = 2;
  localparam int P_HW  = 0;
  localparam int P_EXT = 1;

  logic             halted_q, post_rst_q, pc_ld_q;
  logic             priv_q, resume_q, rstexc_q;
  logic [3:0]       pst_q;
  logic [SRC_W-1:0] src_q;
  resume_kind_t     kind_q;

  logic             waiting, in_win, win_done;
  logic             running, take, insn_ok;
  logic [NPEND-1:0] pend, pend_set;
  logic [SRC_W-1:0] req, win;

  assign running = !waiting && !halted_q;
  assign insn_ok = !user_mode_i || uhe_i;

  always_comb begin
    req           = '0;
    req[SRC_FOF]  = running && fof_i;
    req[SRC_HW]   = running && insn_bound_i && pend[P_HW];
    req[SRC_INSN] = running && halt_insn_i && insn_ok;
    req[SRC_EXT]  = (running && insn_bound_i && pend[P_EXT])
                 || (running && stopped_i && ext_bkpt_i)
                 || (in_win && ext_bkpt_i);
  end

  assign take = |req;
  assign pend_set[P_HW]  = hwbp_i;
  assign pend_set[P_EXT] = ext_bkpt_i;

  dbg_rst_window #(.WAIT_CYC(RST_WAIT), .WIN_CYC(RST_WIN)) u_win (
    .clk       (clk),
    .rst       (rst),
    .abort_i   (take),
    .waiting_o (waiting),
    .in_win_o  (in_win),
    .done_o    (win_done)
  );

  dbg_pend_flags #(.N(NPEND)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .arm_i  (!halted_q),
    .set_i  (pend_set),
    .clr_i  (take),
    .pend_o (pend)
  );

  dbg_halt_prio #(.W(SRC_W)) u_prio (
    .req_i (req),
    .win_o (win)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      halted_q   <= 1'b0;
      post_rst_q <= 1'b0;
      pc_ld_q    <= 1'b0;
      priv_q     <= 1'b0;
      resume_q   <= 1'b0;
      rstexc_q   <= 1'b0;
      pst_q      <= PST_RUNNING;
      src_q      <= '0;
      kind_q     <= RES_NEXT;
    end else begin
      resume_q <= 1'b0;
      priv_q   <= 1'b0;
      rstexc_q <= win_done;
      if (take) begin
        halted_q   <= 1'b1;
        pst_q      <= PST_HALTED;
        src_q      <= win;
        post_rst_q <= waiting;
        pc_ld_q    <= 1'b0;
      end else if (halted_q) begin
        if (pc_wr_i) pc_ld_q <= 1'b1;
        if (go_i) begin
          halted_q   <= 1'b0;
          pst_q      <= PST_RUNNING;
          resume_q   <= 1'b1;
          post_rst_q <= 1'b0;
          if (pc_ld_q)         kind_q <= RES_PC;
          else if (post_rst_q) kind_q <= RES_RESET;
          else                 kind_q <= RES_NEXT;
        end
      end else if (running && halt_insn_i && !insn_ok) begin
        priv_q <= 1'b1;
      end
    end
  end

  assign halt_o        = halted_q;
  assign pst_o         = pst_q;
  assign src_o         = src_q;
  assign priv_viol_o   = priv_q;
  assign resume_o      = resume_q;
  assign resume_kind_o = kind_q;
  assign rst_exc_o     = rstexc_q;

  assert_pst_halted_R11: assert property (@(posedge clk) disable iff (rst)
    halt_o == (pst_o == PST_HALTED));
  assert_src_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    halt_o |-> $onehot(src_o));
  assert_resume_exit_R12: assert property (@(posedge clk) disable iff (rst)
    resume_o |-> !halt_o && $past(halt_o));
  assert_priv_nohalt_R7: assert property (@(posedge clk) disable iff (rst)
    priv_viol_o |-> !halt_o && !$past(halt_o));
  assert_rstexc_run_R2: assert property (@(posedge clk) disable iff (rst)
    rst_exc_o |-> !halt_o);
  assert_src_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !$rose(halt_o) |-> $stable(src_o));
  assert_fof_now_R5: assert property (@(posedge clk) disable iff (rst)
    (running && fof_i) |=> halt_o && src_o == 4'b1000);
endmodule

// File: tb/dbg_halt_ctrl_bench.sv
module dbg_halt_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fof_i = 0, hwbp_i = 0, halt_insn_i = 0, user_mode_i = 0, uhe_i = 0;
  logic ext_bkpt_i = 0, stopped_i = 0, insn_bound_i = 0, go_i = 0, pc_wr_i = 0;
  logic       halt_o, priv_viol_o, resume_o, rst_exc_o;
  logic [3:0] pst_o, src_o;
  logic [1:0] resume_kind_o;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  dbg_halt_ctrl u_dbg_halt_ctrl (
    .clk(clk), .rst(rst), .fof_i(fof_i), .hwbp_i(hwbp_i),
    .halt_insn_i(halt_insn_i), .user_mode_i(user_mode_i), .uhe_i(uhe_i),
    .ext_bkpt_i(ext_bkpt_i), .stopped_i(stopped_i), .insn_bound_i(insn_bound_i),
    .go_i(go_i), .pc_wr_i(pc_wr_i), .halt_o(halt_o), .pst_o(pst_o),
    .src_o(src_o), .priv_viol_o(priv_viol_o), .resume_o(resume_o),
    .resume_kind_o(resume_kind_o), .rst_exc_o(rst_exc_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_inputs();
    fof_i = 0; hwbp_i = 0; halt_insn_i = 0; user_mode_i = 0; uhe_i = 0;
    ext_bkpt_i = 0; stopped_i = 0; insn_bound_i = 0; go_i = 0; pc_wr_i = 0;
  endtask

  task automatic do_reset();
    clear_inputs();
    rst = 1;
    step();
    step();
    rst = 0;
  endtask

  task automatic reset_to_run();
    do_reset();
    repeat (16) step();
  endtask

  task automatic send_go(input logic [1:0] kind, input string req);
    go_i = 1; step(); go_i = 0;
    chk({req, " resume pulse"}, resume_o, 1);
    chk({req, " halt released"}, halt_o, 0);
    chk({req, " resume kind"}, resume_kind_o, kind);
    step();
    chk("R12 resume one cycle", resume_o, 0);
  endtask

  task automatic t_reset();
    clear_inputs();
    rst = 1; step();
    chk("R1 halt", halt_o, 0);
    chk("R1 pst", pst_o, 0);
    chk("R1 src", src_o, 0);
    chk("R1 resume/priv/rstexc", {resume_o, priv_viol_o, rst_exc_o}, 0);
  endtask

  task automatic t_rst_wait();
    do_reset();
    repeat (15) step();
    chk("R2 no start after 15", rst_exc_o, 0);
    step();
    chk("R2 start after 16", rst_exc_o, 1);
    chk("R2 not halted", halt_o, 0);
    step();
    chk("R2 single pulse", rst_exc_o, 0);
  endtask

  task automatic t_window(input int k, input bit write_pc);
    int seen = 0;
    do_reset();
    repeat (k - 1) step();
    ext_bkpt_i = 1; step(); ext_bkpt_i = 0;
    chk("R3 window halt", halt_o, 1);
    chk("R3 window src", src_o, 4'b0001);
    chk("R11 pst halted", pst_o, 4'hF);
    for (int i = 0; i < 20; i++) begin
      step();
      if (rst_exc_o) seen++;
    end
    chk("R3 no reset start", seen, 0);
    if (write_pc) begin
      pc_wr_i = 1; step(); pc_wr_i = 0;
      send_go(2'b01, "R4 pc loaded");
    end else begin
      send_go(2'b10, "R4 reset continue");
    end
  endtask

  task automatic t_window_late();
    do_reset();
    repeat (8) step();
    ext_bkpt_i = 1; step(); ext_bkpt_i = 0;
    chk("R3 edge 9 no halt", halt_o, 0);
  endtask

  task automatic t_fof();
    reset_to_run();
    fof_i = 1; step(); fof_i = 0;
    chk("R5 fof halt", halt_o, 1);
    chk("R5 fof src", src_o, 4'b1000);
    send_go(2'b00, "R12 fof go");
    chk("R11 pst running", pst_o, 0);
    chk("R13 src held", src_o, 4'b1000);
  endtask

  task automatic t_insn();
    reset_to_run();
    halt_insn_i = 1; step(); halt_insn_i = 0;
    chk("R6 supervisor halt", halt_o, 1);
    chk("R6 src", src_o, 4'b0010);
    send_go(2'b00, "R6 next insn");
    user_mode_i = 1; uhe_i = 1; halt_insn_i = 1; step(); halt_insn_i = 0;
    chk("R6 user enabled halt", halt_o, 1);
    send_go(2'b00, "R6 user go");
    uhe_i = 0; halt_insn_i = 1; step(); halt_insn_i = 0;
    chk("R7 priv raised", priv_viol_o, 1);
    chk("R7 no halt", halt_o, 0);
    step();
    chk("R7 priv one cycle", priv_viol_o, 0);
    user_mode_i = 0;
  endtask

  task automatic t_pend();
    reset_to_run();
    hwbp_i = 1; step(); hwbp_i = 0;
    chk("R8 trigger pends", halt_o, 0);
    repeat (3) step();
    chk("R8 waits for boundary", halt_o, 0);
    insn_bound_i = 1; step(); insn_bound_i = 0;
    chk("R8 boundary halt", halt_o, 1);
    chk("R8 hw src", src_o, 4'b0100);
    send_go(2'b00, "R12 pend go");
    insn_bound_i = 1; step(); insn_bound_i = 0;
    chk("R13 pending cleared", halt_o, 0);
    ext_bkpt_i = 1; insn_bound_i = 1; step(); ext_bkpt_i = 0;
    chk("R8 same-cycle boundary not taken", halt_o, 0);
    step(); insn_bound_i = 0;
    chk("R8 next boundary taken", halt_o, 1);
    chk("R8 ext src", src_o, 4'b0001);
    send_go(2'b00, "R12 ext go");
  endtask

  task automatic t_prio();
    reset_to_run();
    hwbp_i = 1; ext_bkpt_i = 1; step(); hwbp_i = 0; ext_bkpt_i = 0;
    insn_bound_i = 1; fof_i = 1; halt_insn_i = 1; step();
    insn_bound_i = 0; fof_i = 0; halt_insn_i = 0;
    chk("R9 fof wins", src_o, 4'b1000);
    send_go(2'b00, "R9 go a");
    hwbp_i = 1; ext_bkpt_i = 1; step(); hwbp_i = 0; ext_bkpt_i = 0;
    insn_bound_i = 1; halt_insn_i = 1; step();
    insn_bound_i = 0; halt_insn_i = 0;
    chk("R9 hw beats insn", src_o, 4'b0100);
    send_go(2'b00, "R9 go b");
    ext_bkpt_i = 1; step(); ext_bkpt_i = 0;
    insn_bound_i = 1; halt_insn_i = 1; step();
    insn_bound_i = 0; halt_insn_i = 0;
    chk("R9 insn beats ext", src_o, 4'b0010);
    send_go(2'b00, "R9 go c");
  endtask

  task automatic t_stop();
    reset_to_run();
    stopped_i = 1; step();
    chk("R10 stop alone no halt", halt_o, 0);
    ext_bkpt_i = 1; step(); ext_bkpt_i = 0;
    chk("R10 stop exit halt", halt_o, 1);
    chk("R10 src", src_o, 4'b0001);
    stopped_i = 0;
    send_go(2'b00, "R10 after stop");
  endtask

  task automatic t_go_idle();
    reset_to_run();
    go_i = 1; step(); go_i = 0;
    chk("R12 idle go no resume", resume_o, 0);
    chk("R12 idle go no halt", halt_o, 0);
    chk("R12 idle go pst", pst_o, 0);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_rst_wait();
    t_window(1, 1'b1);
    t_window(8, 1'b0);
    t_window_late();
    t_fof();
    t_insn();
    t_pend();
    t_prio();
    t_stop();
    t_go_idle();
    report();
  end
endmodule